// File: doc/BRIEF.md
# QDR Port Select Arbiter

This block sits at the command edge of a quad-data-rate memory with one read port and one write port that share a single address bus. On every rising clock edge it samples the two active-low port selects and decides whether a read burst, a write burst or nothing begins. Each burst occupies its port for two cycles, so the block refuses a second start of the same kind on the cycle right after the first one.

The block keeps a record of what started on the previous edge. When both selects are low together, that record decides which port wins. From an idle state the read goes first. After a read the write wins, and after a write the read wins. If both selects stay low, the starts alternate strictly, beginning with a read.

The outputs are two single-cycle start strobes. Each strobe comes with the address taken from the shared bus on the edge that caused it. The two strobes drive the read and write burst engines, which live outside this block.

Top module: `qdr_port_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both start strobes are low and both address outputs are zero; nothing is pending.
- R2: The port selects and the address bus are sampled only at the rising clock edge. An accepted request raises its start strobe for exactly the one cycle that follows that edge.
- R3: A read request alone (read select low, write select high) is accepted whenever no read started on the previous edge. A write request alone is accepted whenever no write started on the previous edge.
- R4: A read request made on the edge right after a read started is ignored. A read request on the next edge after that is accepted.
- R5: A write request made on the edge right after a write started is ignored. A write request on the next edge after that is accepted.
- R6: If both selects are low and nothing started on the previous edge, the read starts and the write does not.
- R7: If both selects are low and a read started on the previous edge, the write starts.
- R8: If both selects are low and a write started on the previous edge, the read starts.
- R9: Holding both selects low from an idle state gives the start sequence read, write, read, write, and so on.
- R10: The read and write start strobes are never high in the same cycle.
- R11: The read address output shows the bus value from the edge that raised the read strobe, and it holds that value until the next read start. The write address output behaves the same way for write starts.
- R12: Deselecting one port has no effect on the other port. A write stream with the read port idle, or a read stream with the write port idle, is accepted on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for sampling and for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read port select, active low |
| wr_sel_n | input | 1 | Write port select, active low |
| addr_in | input | ADDR_W | Shared address bus used by both ports |
| rd_start | output | 1 | One-cycle pulse that begins a read burst |
| wr_start | output | 1 | One-cycle pulse that begins a write burst |
| rd_addr | output | ADDR_W | Address captured for the most recent read start |
| wr_addr | output | ADDR_W | Address captured for the most recent write start |

## Verification
Both port selects can be low on the same edge, and that is the only point where the two ports compete. The bench provokes this on purpose: from idle, right after a read, right after a write, and through long stretches with both selects held low. It also mixes in random select patterns so that collisions occur after every kind of previous start. Each outcome is compared with a bench model built from the previous-start rule. The check confirms that exactly the expected strobe rises, that the losing port's strobe and address stay unchanged, and that the winner's address equals the bus value from that edge.

// File: rtl/qpa_pkg.sv
package qpa_pkg;

   // Kind of burst that began on the most recent sampling edge
   typedef enum logic [1:0] {
      LAST_NONE = 2'd0,
      LAST_RD   = 2'd1,
      LAST_WR   = 2'd2
   } last_op_e;

   localparam int unsigned NUM_PORTS = 2;
   localparam int unsigned PORT_RD   = 0;
   localparam int unsigned PORT_WR   = 1;

endpackage

// File: rtl/qpa_grant.sv
module qpa_grant
   import qpa_pkg::*;
(
   input  logic     rd_req,
   input  logic     wr_req,
   input  last_op_e last_op,
   output logic     grant_rd,
   output logic     grant_wr
);

   logic rd_allowed;
   logic wr_allowed;

   // A port that began a two-cycle burst on the previous edge is still busy
   always_comb begin
      rd_allowed = rd_req && (last_op != LAST_RD);
      wr_allowed = wr_req && (last_op != LAST_WR);
   end

   // Collision: read is ahead unless the last start was a read
   always_comb begin
      grant_rd = 1'b0;
      grant_wr = 1'b0;
      unique case (last_op)
         LAST_RD: grant_wr = wr_allowed;
         LAST_WR: grant_rd = rd_allowed;
         default: begin
            grant_rd = rd_allowed;
            grant_wr = wr_allowed && !rd_allowed;
         end
      endcase
   end

   // R10: the two grants never coincide
   always_comb begin
      a_r10_grant_excl: assert (!(grant_rd && grant_wr));
   end

endmodule

// File: rtl/qpa_history.sv
module qpa_history
   import qpa_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     grant_rd,
   input  logic     grant_wr,
   output last_op_e last_op,
   output logic     rd_start,
   output logic     wr_start
);

   last_op_e last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        last_q <= LAST_NONE;
      else if (grant_rd) last_q <= LAST_RD;
      else if (grant_wr) last_q <= LAST_WR;
      else               last_q <= LAST_NONE;
   end

   assign last_op  = last_q;
   assign rd_start = (last_q == LAST_RD);
   assign wr_start = (last_q == LAST_WR);

   // R4: no read start on two consecutive cycles
   a_r4_no_rd_pair: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> !rd_start);

   // R5: no write start on two consecutive cycles
   a_r5_no_wr_pair: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> !wr_start);

endmodule

// File: rtl/qpa_addr_capture.sv
module qpa_addr_capture #(
   parameter int unsigned W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take,
   input  logic [W-1:0] bus,
   output logic [W-1:0] held
);

   logic [W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held_q <= '0;
      else if (take) held_q <= bus;
   end

   assign held = held_q;

   // R11: the held value changes only on the cycle after a capture
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(held));

endmodule

// File: rtl/qdr_port_arbiter.sv
module qdr_port_arbiter
   import qpa_pkg::*;
#(
   parameter int unsigned ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_sel_n,
   input  logic              wr_sel_n,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              rd_start,
   output logic              wr_start,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] wr_addr
);

   localparam int unsigned AW = ADDR_W;

   initial begin
      a_addr_w_range: assert (AW >= 1 && AW <= 64);
   end

   logic     rd_req;
   logic     wr_req;
   logic     grant_rd;
   logic     grant_wr;
   last_op_e last_op;

   logic [NUM_PORTS-1:0]         take_vec;
   logic [NUM_PORTS-1:0][AW-1:0] held_vec;

   assign rd_req = !rd_sel_n;
   assign wr_req = !wr_sel_n;

   qpa_grant u_grant (
      .rd_req   (rd_req),
      .wr_req   (wr_req),
      .last_op  (last_op),
      .grant_rd (grant_rd),
      .grant_wr (grant_wr)
   );

   qpa_history u_history (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant_rd (grant_rd),
      .grant_wr (grant_wr),
      .last_op  (last_op),
      .rd_start (rd_start),
      .wr_start (wr_start)
   );

   assign take_vec[PORT_RD] = grant_rd;
   assign take_vec[PORT_WR] = grant_wr;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      qpa_addr_capture #(.W(AW)) u_cap (
         .clk   (clk),
         .rst_n (rst_n),
         .take  (take_vec[p]),
         .bus   (addr_in),
         .held  (held_vec[p])
      );
   end

   assign rd_addr = held_vec[PORT_RD];
   assign wr_addr = held_vec[PORT_WR];

   // R10: never both start strobes at once
   a_r10_one_start: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_start, wr_start}));

   // R3/R8: a read request is taken unless a read just started
   a_r3_rd_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_sel_n && !rd_start) |=> rd_start);

   // R3/R12: a lone write request is taken unless a write just started
   a_r12_wr_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_sel_n && rd_sel_n && !wr_start) |=> wr_start);

   // R7: collision right after a read goes to the write
   a_r7_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && !rd_sel_n && !wr_sel_n) |=> wr_start);

   // R6: collision from idle goes to the read
   a_r6_rd_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_start && !wr_start && !rd_sel_n && !wr_sel_n) |=> (rd_start && !wr_start));

   // R11: captured address equals the bus at the granting edge
   a_r11_rd_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_sel_n && !rd_start) |=> (rd_addr == $past(addr_in)));

   // R2: with both selects high nothing starts next cycle
   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel_n && wr_sel_n) |=> (!rd_start && !wr_start));

endmodule

// File: tb/test_qdr_port_arbiter.sv
module test_qdr_port_arbiter;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_sel_n = 1'b1;
   logic          wr_sel_n = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic          rd_start;
   logic          wr_start;
   logic [AW-1:0] rd_addr;
   logic [AW-1:0] wr_addr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Bench model of the outputs after the next edge
   logic          m_rd = 1'b0;
   logic          m_wr = 1'b0;
   logic [AW-1:0] m_rda = '0;
   logic [AW-1:0] m_wra = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qdr_port_arbiter #(.ADDR_W(AW)) i_qdr_port_arbiter (
      .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
      .addr_in(addr_in), .rd_start(rd_start), .wr_start(wr_start),
      .rd_addr(rd_addr), .wr_addr(wr_addr)
   );

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Which rule the next decision falls under
   function automatic string rule_tag(input logic rr, input logic wr, input logic prd, input logic pwr);
      if (rr && wr) begin
         if (prd)      return "R7";
         else if (pwr) return "R8";
         else          return "R6";
      end
      if (rr && prd) return "R4";
      if (wr && pwr) return "R5";
      if (rr || wr)  return "R3";
      return "R2";
   endfunction

   // Apply one cycle of inputs, then check outputs at the following negedge
   task automatic step(input logic rn, input logic wn, input logic [AW-1:0] a, input string extra);
      logic rr, wr, nrd, nwr;
      string t;
      rr = !rn;
      wr = !wn;
      rd_sel_n = rn;
      wr_sel_n = wn;
      addr_in  = a;
      t = rule_tag(rr, wr, m_rd, m_wr);
      nrd = 1'b0;
      nwr = 1'b0;
      if (m_rd)      nwr = wr;
      else if (m_wr) nrd = rr;
      else begin
         nrd = rr;
         nwr = wr && !rr;
      end
      m_rd = nrd;
      m_wr = nwr;
      if (nrd) m_rda = a;
      if (nwr) m_wra = a;
      @(negedge clk);
      chk({t, extra, " rd_start"}, AW'(rd_start), AW'(m_rd));
      chk({t, extra, " wr_start"}, AW'(wr_start), AW'(m_wr));
      chk("R10 exclusive", AW'(rd_start && wr_start), '0);
      chk("R11 rd_addr", rd_addr, m_rda);
      chk("R11 wr_addr", wr_addr, m_wra);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] ra;
      void'($urandom(32'h5EED_0A17));
      rd_sel_n = 1'b0;
      wr_sel_n = 1'b0;
      addr_in  = 20'hABCDE;
      repeat (3) @(negedge clk);
      chk("R1 rd_start in reset", AW'(rd_start), '0);
      chk("R1 wr_start in reset", AW'(wr_start), '0);
      chk("R1 rd_addr in reset", rd_addr, '0);
      chk("R1 wr_addr in reset", wr_addr, '0);
      rd_sel_n = 1'b1;
      wr_sel_n = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rd_start after reset", AW'(rd_start), '0);
      chk("R1 wr_start after reset", AW'(wr_start), '0);

      // R9: both held low from idle alternates starting with read
      for (int i = 0; i < 6; i++) begin
         step(1'b0, 1'b0, AW'(20'h10 + i), " R9");
         chk("R9 alternation rd", AW'(rd_start), AW'((i % 2) == 0));
         chk("R9 alternation wr", AW'(wr_start), AW'((i % 2) == 1));
      end
      step(1'b1, 1'b1, '0, " idle");
      step(1'b1, 1'b1, '0, " idle");

      // R4: back-to-back read, second dropped, third taken
      step(1'b0, 1'b1, 20'h00111, "");
      step(1'b0, 1'b1, 20'h00222, "");
      chk("R4 rd_addr kept", rd_addr, 20'h00111);
      step(1'b0, 1'b1, 20'h00333, "");
      chk("R4 rd taken after gap", AW'(rd_start), 1);
      step(1'b1, 1'b1, '0, "");

      // R5: back-to-back write
      step(1'b1, 1'b0, 20'h00444, "");
      step(1'b1, 1'b0, 20'h00555, "");
      chk("R5 wr dropped", AW'(wr_start), 0);
      chk("R5 wr_addr kept", wr_addr, 20'h00444);
      step(1'b1, 1'b0, 20'h00666, "");
      step(1'b1, 1'b1, '0, "");

      // R8 after write, R7 after read
      step(1'b1, 1'b0, 20'h00777, "");
      step(1'b0, 1'b0, 20'h00888, "");
      chk("R8 rd after wr", AW'(rd_start), 1);
      step(1'b0, 1'b0, 20'h00999, "");
      chk("R7 wr after rd", AW'(wr_start), 1);
      step(1'b1, 1'b1, '0, "");

      // R12: write stream with read idle, then read stream with write idle
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0, AW'(20'h2000 + i), " R12 wr stream");
      for (int i = 0; i < 8; i++) step(1'b0, 1'b1, AW'(20'h3000 + i), " R12 rd stream");
      chk("R12 wr_addr untouched by reads", wr_addr, 20'h2006);

      // Random mix, biased toward collisions
      for (int i = 0; i < 600; i++) begin
         logic rn, wn;
         rn = ($urandom_range(0, 99) < 40);
         wn = ($urandom_range(0, 99) < 40);
         ra = AW'($urandom);
         step(rn, wn, ra, " rand");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule